// File: doc/BRIEF.md
# Sectored Fully Associative Cache Tag Directory

This block keeps the tags and per-sub-block state of a small fully associative cache. Each line is split into quads of four words. Every quad has its own present, dirty and referenced bit. A probe carries a word address, a read/write flag and a jump flag. The block compares the line address against every entry in one cycle and sorts the probe into one of three cases. A hit means the line is resident and the addressed quad is present. A quad miss means the line is resident but the quad is not. A line miss means no entry holds the line.

On a quad miss the block asks the memory side for that one quad and marks it present. On a line miss it takes the entry under a rotating victim pointer. It sends one write-back request for every dirty quad of the old line, then sends a fill request for the new quad. While any request is open, new probes are held off.

Two mode inputs shape the policy. One lets a hit on the current victim push the pointer forward. The other records references per quad. Event counters tally the probe traffic. A flush input empties the directory and keeps the counters.

Top module: `cache_tag_top`

## Requirements
- R1: A word address splits into a line tag (bits above the line offset) and a quad index (offset bits above bit 1). With the default two quads per line, bit 2 is the quad index and bits 15:3 are the tag. A fill request carries the probe address with bits 1:0 cleared. The reported result code is 0 for a hit, 1 for a quad miss and 2 for a line miss, and it appears one cycle after the probe is accepted.
- R2: A probe whose line is resident and whose quad is present reports a hit, raises no request, and leaves probeReady high.
- R3: A probe whose line is resident but whose quad is absent raises one fill request and no write-back. It marks the quad present, so a later probe to the same quad hits.
- R4: On a line miss, the entry at the victim pointer is replaced. One write-back request is issued for each of its dirty quads, in ascending quad order, at the address of the old line's quad. Each acknowledged write-back adds one to the dirty write-back counter.
- R5: The fill request of a line miss is raised only after the last write-back has been acknowledged. Every request is held until it is acknowledged, and probeReady stays low until the fill is acknowledged.
- R6: The victim pointer advances by one after every line miss, and wraps from the last entry to zero.
- R7: With shiftOnHit high, a hit or quad miss on the entry under the victim pointer advances the pointer. With shiftOnHit low, such a probe leaves the pointer unchanged.
- R8: A write sets the dirty bit of the addressed quad. The writes-to-clean counter goes up only when that quad was clean before the write; this includes the write that brings in a new line.
- R9: Counters track all accepted probes, reads, writes, write misses (of either kind), quad misses, line misses, and misses on probes flagged as jumps. A hit flagged as a jump is not counted as a jump miss.
- R10: With pseudoLru high, a probe that finds its line sets the referenced bit of the addressed quad. The line's referenced bits after the update are reported with the result. With pseudoLru low, no bit is set. A replaced line starts with all referenced bits clear.
- R11: A flush empties every entry, drops its dirty state without write-backs, and returns the victim pointer to zero, while the counters are kept. Reset also zeroes every counter.
- R12: After reset or flush, no empty entry matches. The first probe to any address is a line miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the directory; taken when idle, ahead of a probe |
| shiftOnHit | input | 1 | Mode: a hit on the victim entry advances the pointer |
| pseudoLru | input | 1 | Mode: record per-quad references |
| probeValid | input | 1 | Probe request |
| probeWrite | input | 1 | Probe is a write |
| probeJump | input | 1 | Probe comes from a jump |
| probeAddr | input | ADDR_W | Word address of the probe |
| probeReady | output | 1 | Probe accepted when high together with probeValid |
| resultValid | output | 1 | One-cycle pulse with the probe outcome |
| resultKind | output | 2 | 0 hit, 1 quad miss, 2 line miss |
| resultRef | output | QUADS | Referenced bits of the probed line after update |
| victimIdx | output | log2(LINES) | Current victim pointer |
| wbValid | output | 1 | Write-back request for one dirty quad |
| wbAddr | output | ADDR_W | Quad-aligned address of the write-back |
| wbAck | input | 1 | Write-back accepted |
| fillValid | output | 1 | Fill request for one quad |
| fillAddr | output | ADDR_W | Quad-aligned address of the fill |
| fillAck | input | 1 | Fill completed |
| cntProbe | output | CNT_W | Accepted probes |
| cntRead | output | CNT_W | Read probes |
| cntWrite | output | CNT_W | Write probes |
| cntWriteMiss | output | CNT_W | Writes that missed |
| cntWriteClean | output | CNT_W | Writes to a clean quad |
| cntQuadMiss | output | CNT_W | Quad misses |
| cntLineMiss | output | CNT_W | Line misses |
| cntJumpMiss | output | CNT_W | Misses on jump probes |
| cntDirtyWb | output | CNT_W | Acknowledged write-backs |

## Verification
The probe sequence first fills every entry from empty. It then revisits those lines at present quads, at absent quads and with writes to both clean and dirty quads. Each probe separates hits, quad misses and line misses, and shows whether a write bumps the clean-write count. A line miss on a victim with two dirty quads checks write-back order and addresses, and that the fill is held back until both write-backs are acknowledged. A line miss on a clean victim must show no write-back. Repeated hits on and off the victim entry, under both settings of shiftOnHit, show when the pointer moves. The wrap back to zero, the effect of the referenced-bit mode, and flush against reset are each checked: flush keeps counters and drops dirty data, reset clears everything.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  typedef enum logic [1:0] {
    KIND_HIT   = 2'd0,
    KIND_QMISS = 2'd1,
    KIND_LMISS = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic flushNow;
    logic wbPop;
  } ctlStrobes_t;

endpackage

// File: rtl/cache_tag_ctl.sv
module cache_tag_ctl
  import cache_tag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        probeValid,
  input  logic        lookHit,
  input  logic        lookPresent,
  input  logic        wbPending,
  input  logic        wbAck,
  input  logic        fillAck,
  output ctlStrobes_t stb,
  output logic        probeReady,
  output logic        wbValid,
  output logic        fillValid
);

  state_e stQ, stNxt;

  always_comb begin
    stb.flushNow = (stQ == ST_IDLE) && flush;
    stb.accept   = (stQ == ST_IDLE) && !flush && probeValid;
    stb.wbPop    = (stQ == ST_WB) && wbPending && wbAck;
    probeReady   = (stQ == ST_IDLE) && !flush;
    wbValid      = (stQ == ST_WB) && wbPending;
    fillValid    = (stQ == ST_FILL);
  end

  always_comb begin
    stNxt = stQ;
    case (stQ)
      ST_IDLE: if (stb.accept) begin
        if (!lookHit)          stNxt = ST_WB;
        else if (!lookPresent) stNxt = ST_FILL;
      end
      ST_WB:   if (!wbPending) stNxt = ST_FILL;
      ST_FILL: if (fillAck)    stNxt = ST_IDLE;
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNxt;

  // R5: at most one memory request at a time
  a_r5_one_request: assert property (@(posedge clk) disable iff (!rstN)
    !(wbValid && fillValid));
  // R5: fill only after every write-back is gone
  a_r5_fill_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> !wbPending);
  // R5: no new probe while a request is open
  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid || fillValid) |-> !probeReady);
  // R5: fill held until acknowledged
  a_r5_fill_held: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !fillAck) |=> fillValid);

endmodule

// File: rtl/cache_tag_dp.sv
module cache_tag_dp
  import cache_tag_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int QUADS  = 2,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int VIC_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic              shiftOnHit,
  input  logic              pseudoLru,
  input  logic              probeWrite,
  input  logic              probeJump,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              lookHit,
  output logic              lookPresent,
  output logic              wbPending,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [ADDR_W-1:0] fillAddr,
  output logic              resultValid,
  output logic [1:0]        resultKind,
  output logic [QUADS-1:0]  resultRef,
  output logic [VIC_W-1:0]  victimIdx,
  output logic [CNT_W-1:0]  cntProbe,
  output logic [CNT_W-1:0]  cntRead,
  output logic [CNT_W-1:0]  cntWrite,
  output logic [CNT_W-1:0]  cntWriteMiss,
  output logic [CNT_W-1:0]  cntWriteClean,
  output logic [CNT_W-1:0]  cntQuadMiss,
  output logic [CNT_W-1:0]  cntLineMiss,
  output logic [CNT_W-1:0]  cntJumpMiss,
  output logic [CNT_W-1:0]  cntDirtyWb
);

  localparam int WPL    = QUADS * 4;
  localparam int OFF_W  = $clog2(WPL);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int QIDX_W = (QUADS > 1) ? $clog2(QUADS) : 1;

  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [QUADS-1:0]  presQ  [LINES];
  logic [QUADS-1:0]  dirtyQ [LINES];
  logic [QUADS-1:0]  refQ   [LINES];
  logic [LINES-1:0]  validQ;
  logic [VIC_W-1:0]  vicQ, vicInc, hitIdx;
  logic [TAG_W-1:0]  wbTagQ;
  logic [QUADS-1:0]  wbMaskQ;
  logic [QIDX_W-1:0] wbQuad;
  logic [ADDR_W-1:0] fillAddrQ;
  logic [1:0]        resKindQ;
  logic [QUADS-1:0]  resRefQ;
  logic              resValidQ;

  logic [TAG_W-1:0]  lineTag;
  logic [QIDX_W-1:0] quadIdx;
  logic [QUADS-1:0]  quadBit;
  logic              missAny, cleanWrite;

  assign lineTag = probeAddr[ADDR_W-1:OFF_W];
  assign quadIdx = QIDX_W'((probeAddr >> 2) & ADDR_W'(QUADS - 1));
  assign quadBit = QUADS'(1) << quadIdx;
  assign vicInc  = (vicQ == VIC_W'(LINES - 1)) ? '0 : vicQ + 1'b1;

  // parallel compare against every entry
  always_comb begin
    lookHit = 1'b0;
    hitIdx  = '0;
    for (int i = 0; i < LINES; i++)
      if (validQ[i] && tagQ[i] == lineTag) begin
        lookHit = 1'b1;
        hitIdx  = VIC_W'(i);
      end
  end
  assign lookPresent = |(presQ[hitIdx] & quadBit);
  assign missAny     = !lookHit || !lookPresent;
  assign cleanWrite  = probeWrite && (!lookHit || !(|(dirtyQ[hitIdx] & quadBit)));

  // lowest dirty quad goes out first
  always_comb begin
    wbQuad = '0;
    for (int q = QUADS - 1; q >= 0; q--)
      if (wbMaskQ[q]) wbQuad = QIDX_W'(q);
  end
  assign wbPending = |wbMaskQ;
  assign wbAddr    = {wbTagQ, {OFF_W{1'b0}}} | (ADDR_W'(wbQuad) << 2);
  assign fillAddr  = fillAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      vicQ      <= '0;
      wbTagQ    <= '0;
      wbMaskQ   <= '0;
      fillAddrQ <= '0;
      resValidQ <= 1'b0;
      resKindQ  <= KIND_HIT;
      resRefQ   <= '0;
      for (int i = 0; i < LINES; i++) begin
        tagQ[i]   <= '0;
        presQ[i]  <= '0;
        dirtyQ[i] <= '0;
        refQ[i]   <= '0;
      end
    end else begin
      resValidQ <= stb.accept;
      if (stb.flushNow) begin
        validQ <= '0;
        vicQ   <= '0;
        for (int i = 0; i < LINES; i++) begin
          presQ[i]  <= '0;
          dirtyQ[i] <= '0;
          refQ[i]   <= '0;
        end
      end else if (stb.accept) begin
        fillAddrQ <= probeAddr & ~ADDR_W'(3);
        if (lookHit) begin
          resKindQ      <= lookPresent ? KIND_HIT : KIND_QMISS;
          presQ[hitIdx] <= presQ[hitIdx] | quadBit;
          if (probeWrite) dirtyQ[hitIdx] <= dirtyQ[hitIdx] | quadBit;
          if (pseudoLru)  refQ[hitIdx]   <= refQ[hitIdx] | quadBit;
          resRefQ <= refQ[hitIdx] | (pseudoLru ? quadBit : '0);
          if (shiftOnHit && hitIdx == vicQ) vicQ <= vicInc;
        end else begin
          resKindQ     <= KIND_LMISS;
          wbTagQ       <= tagQ[vicQ];
          wbMaskQ      <= validQ[vicQ] ? dirtyQ[vicQ] : '0;
          tagQ[vicQ]   <= lineTag;
          validQ[vicQ] <= 1'b1;
          presQ[vicQ]  <= quadBit;
          dirtyQ[vicQ] <= probeWrite ? quadBit : '0;
          refQ[vicQ]   <= '0;
          resRefQ      <= '0;
          vicQ         <= vicInc;
        end
      end else if (stb.wbPop) begin
        wbMaskQ <= wbMaskQ & ~(QUADS'(1) << wbQuad);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntProbe <= '0; cntRead <= '0; cntWrite <= '0; cntWriteMiss <= '0;
      cntWriteClean <= '0; cntQuadMiss <= '0; cntLineMiss <= '0;
      cntJumpMiss <= '0; cntDirtyWb <= '0;
    end else begin
      if (stb.accept) begin
        cntProbe <= cntProbe + 1'b1;
        if (probeWrite) cntWrite <= cntWrite + 1'b1;
        else            cntRead  <= cntRead + 1'b1;
        if (probeWrite && missAny) cntWriteMiss <= cntWriteMiss + 1'b1;
        if (cleanWrite)            cntWriteClean <= cntWriteClean + 1'b1;
        if (lookHit && !lookPresent) cntQuadMiss <= cntQuadMiss + 1'b1;
        if (!lookHit)              cntLineMiss <= cntLineMiss + 1'b1;
        if (probeJump && missAny)  cntJumpMiss <= cntJumpMiss + 1'b1;
      end
      if (stb.wbPop) cntDirtyWb <= cntDirtyWb + 1'b1;
    end
  end

  assign resultValid = resValidQ;
  assign resultKind  = resKindQ;
  assign resultRef   = resRefQ;
  assign victimIdx   = vicQ;

  // R6: a line miss always moves the pointer
  a_r6_line_miss_moves: assert property (@(posedge clk) disable iff (!rstN)
    ((LINES > 1) && stb.accept && !lookHit) |=> (victimIdx != $past(victimIdx)));
  // R11: flush empties the directory and rewinds the pointer
  a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.flushNow |=> (validQ == '0 && victimIdx == '0));
  // R8: a write hit leaves the quad dirty
  a_r8_write_dirty: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && probeWrite && lookHit) |=> ((dirtyQ[$past(hitIdx)] & $past(quadBit)) != '0));
  // R4: a write-back address is stable until popped
  a_r4_wb_stable: assert property (@(posedge clk) disable iff (!rstN)
    (wbPending && !stb.wbPop) |=> $stable(wbAddr));
  // R12: after a flush the next probe cannot hit
  a_r12_empty_no_match: assert property (@(posedge clk) disable iff (!rstN)
    (validQ == '0) |-> !lookHit);

endmodule

// File: rtl/cache_tag_top.sv
module cache_tag_top
  import cache_tag_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int QUADS  = 2,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int VIC_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              shiftOnHit,
  input  logic              pseudoLru,
  input  logic              probeValid,
  input  logic              probeWrite,
  input  logic              probeJump,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeReady,
  output logic              resultValid,
  output logic [1:0]        resultKind,
  output logic [QUADS-1:0]  resultRef,
  output logic [VIC_W-1:0]  victimIdx,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  input  logic              wbAck,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillAck,
  output logic [CNT_W-1:0]  cntProbe,
  output logic [CNT_W-1:0]  cntRead,
  output logic [CNT_W-1:0]  cntWrite,
  output logic [CNT_W-1:0]  cntWriteMiss,
  output logic [CNT_W-1:0]  cntWriteClean,
  output logic [CNT_W-1:0]  cntQuadMiss,
  output logic [CNT_W-1:0]  cntLineMiss,
  output logic [CNT_W-1:0]  cntJumpMiss,
  output logic [CNT_W-1:0]  cntDirtyWb
);

  ctlStrobes_t stb;
  logic lookHit, lookPresent, wbPending;

  cache_tag_ctl ctl_i (
    .clk, .rstN, .flush, .probeValid, .lookHit, .lookPresent, .wbPending,
    .wbAck, .fillAck, .stb, .probeReady, .wbValid, .fillValid
  );

  cache_tag_dp #(.LINES(LINES), .QUADS(QUADS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk, .rstN, .stb, .shiftOnHit, .pseudoLru, .probeWrite, .probeJump, .probeAddr,
    .lookHit, .lookPresent, .wbPending, .wbAddr, .fillAddr, .resultValid,
    .resultKind, .resultRef, .victimIdx, .cntProbe, .cntRead, .cntWrite,
    .cntWriteMiss, .cntWriteClean, .cntQuadMiss, .cntLineMiss, .cntJumpMiss,
    .cntDirtyWb
  );

endmodule

// File: tb/cache_tag_top_tb_top.sv
`timescale 1ns/1ps
module cache_tag_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, shiftOnHit = 1'b0, pseudoLru = 1'b0;
  logic probeValid = 1'b0, probeWrite = 1'b0, probeJump = 1'b0;
  logic [15:0] probeAddr = '0;
  logic wbAck = 1'b0, fillAck = 1'b0;
  logic probeReady, resultValid, wbValid, fillValid;
  logic [1:0] resultKind, resultRef, victimIdx;
  logic [15:0] wbAddr, fillAddr;
  logic [15:0] cntProbe, cntRead, cntWrite, cntWriteMiss, cntWriteClean;
  logic [15:0] cntQuadMiss, cntLineMiss, cntJumpMiss, cntDirtyWb;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;
  int eProbe = 0, eRead = 0, eWrite = 0, eWMiss = 0, eWClean = 0;
  int eQMiss = 0, eLMiss = 0, eJMiss = 0, eDWb = 0;

  always #4 clk = ~clk;

  cache_tag_top dut_i (
    .clk, .rstN, .flush, .shiftOnHit, .pseudoLru, .probeValid, .probeWrite,
    .probeJump, .probeAddr, .probeReady, .resultValid, .resultKind, .resultRef,
    .victimIdx, .wbValid, .wbAddr, .wbAck, .fillValid, .fillAddr, .fillAck,
    .cntProbe, .cntRead, .cntWrite, .cntWriteMiss, .cntWriteClean, .cntQuadMiss,
    .cntLineMiss, .cntJumpMiss, .cntDirtyWb
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkCounters(input string req);
    chk(cntProbe == 16'(eProbe), {req, " probes"}, cntProbe, eProbe);
    chk(cntRead == 16'(eRead), {req, " reads"}, cntRead, eRead);
    chk(cntWrite == 16'(eWrite), {req, " writes"}, cntWrite, eWrite);
    chk(cntWriteMiss == 16'(eWMiss), {req, " write misses"}, cntWriteMiss, eWMiss);
    chk(cntWriteClean == 16'(eWClean), {req, " writes to clean"}, cntWriteClean, eWClean);
    chk(cntQuadMiss == 16'(eQMiss), {req, " quad misses"}, cntQuadMiss, eQMiss);
    chk(cntLineMiss == 16'(eLMiss), {req, " line misses"}, cntLineMiss, eLMiss);
    chk(cntJumpMiss == 16'(eJMiss), {req, " jump misses"}, cntJumpMiss, eJMiss);
    chk(cntDirtyWb == 16'(eDWb), {req, " dirty write-backs"}, cntDirtyWb, eDWb);
  endtask

  task automatic checkVictim(input int exp, input string req);
    chk(victimIdx == 2'(exp), {req, " victim pointer"}, victimIdx, exp);
  endtask

  // One probe plus servicing of its memory requests.
  task automatic probe(input bit w, input bit j, input logic [15:0] a,
                       input int expKind, input int expNWb,
                       input logic [15:0] wb0, input logic [15:0] wb1,
                       input logic [1:0] expRef, input int wcInc, input string req);
    int nWb = 0;
    bit gotFill = 1'b0;
    @(negedge clk);
    probeWrite = w; probeJump = j; probeAddr = a; probeValid = 1'b1;
    @(negedge clk);
    probeValid = 1'b0;
    chk(resultValid == 1'b1, {req, " R1 result pulse"}, resultValid, 1);
    chk(resultKind == 2'(expKind), {req, " R1 result kind"}, resultKind, expKind);
    chk(resultRef == expRef, {req, " R10 referenced bits"}, resultRef, expRef);
    if (expKind == 0) chk(probeReady == 1'b1, {req, " R2 ready after hit"}, probeReady, 1);
    for (int k = 0; k < 40; k++) begin
      if (wbValid) begin
        if (nWb == 0) chk(wbAddr == wb0, {req, " R4 first write-back"}, wbAddr, wb0);
        else          chk(wbAddr == wb1, {req, " R4 second write-back"}, wbAddr, wb1);
        chk(probeReady == 1'b0, {req, " R5 busy during write-back"}, probeReady, 0);
        nWb++;
        wbAck = 1'b1;
        @(negedge clk);
        wbAck = 1'b0;
      end else if (fillValid) begin
        chk(nWb == expNWb, {req, " R5 fill after write-backs"}, nWb, expNWb);
        chk(fillAddr == (a & 16'hfffc), {req, " R1 fill address"}, fillAddr, a & 16'hfffc);
        chk(probeReady == 1'b0, {req, " R5 busy during fill"}, probeReady, 0);
        gotFill = 1'b1;
        repeat (2) @(negedge clk);
        chk(fillValid == 1'b1, {req, " R5 fill held"}, fillValid, 1);
        fillAck = 1'b1;
        @(negedge clk);
        fillAck = 1'b0;
      end else if (probeReady) begin
        break;
      end else begin
        @(negedge clk);
      end
    end
    chk(nWb == expNWb, {req, " R4 write-back count"}, nWb, expNWb);
    chk(gotFill == (expKind != 0), {req, " R3 fill issued"}, gotFill, expKind != 0);
    eProbe++;
    if (w) eWrite++; else eRead++;
    if (w && expKind != 0) eWMiss++;
    if (expKind == 1) eQMiss++;
    if (expKind == 2) eLMiss++;
    if (j && expKind != 0) eJMiss++;
    eDWb += expNWb;
    eWClean += wcInc;
  endtask

  task automatic testReset();
    chk(probeReady == 1'b1, "R11 ready after reset", probeReady, 1);
    chk(wbValid == 1'b0 && fillValid == 1'b0, "R11 no request after reset", {wbValid, fillValid}, 0);
    checkVictim(0, "R11");
    checkCounters("R11");
  endtask

  task automatic testFillAndHit();
    probe(0, 0, 16'h0010, 2, 0, 0, 0, 2'b00, 0, "R12 first probe");
    checkVictim(1, "R6");
    probe(0, 0, 16'h0014, 1, 0, 0, 0, 2'b00, 0, "R3 quad miss");
    checkVictim(1, "R3");
    probe(0, 0, 16'h0015, 0, 0, 0, 0, 2'b00, 0, "R3 quad now present");
    probe(0, 0, 16'h0011, 0, 0, 0, 0, 2'b00, 0, "R2 hit");
    probe(1, 0, 16'h0016, 0, 0, 0, 0, 2'b00, 1, "R8 write clean quad");
    probe(1, 0, 16'h0017, 0, 0, 0, 0, 2'b00, 0, "R8 write dirty quad");
    probe(1, 0, 16'h0012, 0, 0, 0, 0, 2'b00, 1, "R8 write other clean quad");
    checkCounters("R8");
  endtask

  task automatic testReplace();
    probe(0, 0, 16'h0020, 2, 0, 0, 0, 2'b00, 0, "R6 fill entry 1");
    probe(0, 0, 16'h0030, 2, 0, 0, 0, 2'b00, 0, "R6 fill entry 2");
    probe(0, 0, 16'h0040, 2, 0, 0, 0, 2'b00, 0, "R6 fill entry 3");
    checkVictim(0, "R6 wrap");
    probe(1, 0, 16'h0050, 2, 2, 16'h0010, 16'h0014, 2'b00, 1, "R4 dirty victim");
    checkVictim(1, "R6 after replace");
    checkCounters("R4");
  endtask

  task automatic testShift();
    shiftOnHit = 1'b1;
    probe(0, 0, 16'h0021, 0, 0, 0, 0, 2'b00, 0, "R7 hit on victim");
    checkVictim(2, "R7 shift on hit");
    probe(0, 0, 16'h0022, 0, 0, 0, 0, 2'b00, 0, "R7 hit off victim");
    checkVictim(2, "R7 off victim");
    shiftOnHit = 1'b0;
    probe(0, 0, 16'h0031, 0, 0, 0, 0, 2'b00, 0, "R7 advance-on-miss hit");
    checkVictim(2, "R7 mode off");
  endtask

  task automatic testLru();
    pseudoLru = 1'b1;
    probe(0, 0, 16'h0034, 1, 0, 0, 0, 2'b10, 0, "R10 quad miss sets bit");
    probe(0, 0, 16'h0030, 0, 0, 0, 0, 2'b11, 0, "R10 hit sets bit");
    pseudoLru = 1'b0;
    probe(0, 0, 16'h0041, 0, 0, 0, 0, 2'b00, 0, "R10 mode off");
  endtask

  task automatic testJumpAndWriteMiss();
    probe(0, 1, 16'h0060, 2, 0, 0, 0, 2'b00, 0, "R9 jump line miss clean victim");
    checkVictim(3, "R9");
    probe(0, 1, 16'h0044, 1, 0, 0, 0, 2'b00, 0, "R9 jump quad miss");
    probe(0, 1, 16'h0045, 0, 0, 0, 0, 2'b00, 0, "R9 jump hit");
    probe(1, 0, 16'h0013, 2, 0, 0, 0, 2'b00, 1, "R9 write line miss");
    checkVictim(0, "R6 second wrap");
    checkCounters("R9");
  endtask

  task automatic testFlushReset();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    checkVictim(0, "R11 flush");
    checkCounters("R11 flush keeps");
    probe(0, 0, 16'h0050, 2, 0, 0, 0, 2'b00, 0, "R11 flush drops dirty line");
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    eProbe = 0; eRead = 0; eWrite = 0; eWMiss = 0; eWClean = 0;
    eQMiss = 0; eLMiss = 0; eJMiss = 0; eDWb = 0;
    checkVictim(0, "R11 reset");
    checkCounters("R11 reset zeroes");
    probe(0, 0, 16'h0013, 2, 0, 0, 0, 2'b00, 0, "R12 after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFillAndHit();
    testReplace();
    testShift();
    testLru();
    testJumpAndWriteMiss();
    testFlushReset();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule